// File: doc/BRIEF.md
# Program-Flash Protection Window Guard

This block guards a 16 KB program-flash region whose last byte sits at global address 0x3_FFFF (the region spans 0x3_C000 to 0x3_FFFF). It keeps an 8-bit protection configuration byte and decodes it into one programmable window at the top of the region. Two control bits decide the window's role: it is ignored, it is the only protected area, or it is the only unprotected area. They can also protect the whole region. Every program, sector-erase or block-erase request is judged against this configuration. The verdict is registered and appears one clock later.

While reset is held, the configuration byte is taken from a nonvolatile input byte. After reset, software may rewrite it. The size of the window can change only while the window is switched off. A rejected request never gets the forwarding verdict (`rsp_ok`), so it does not reach the array. It also sets a sticky violation flag that software clears by writing 1. Requests aimed outside the region get a separate "not mine" verdict, so another guard can handle them.

Top module: `pflash_guard`

## Requirements
- R1: While `rst_n` is low, the configuration byte takes the value of `nv_cfg` on every clock. The response outputs and `viol_flag` read 0.
- R2: A configuration write always sets bit 7 (operation enable) and bit 5 (window disable) from the written data. Bits 6 and 2:0 are reserved: they keep the value loaded in reset whatever is written.
- R3: Bits 4:3 (window size) take the written value only when the stored bit 5 is 1 before the write. Otherwise they keep their old value.
- R4: The window always ends at 0x3_FFFF. Size code 00 starts it at 0x3_F800, 01 at 0x3_F000, 10 at 0x3_E000 and 11 at 0x3_C000.
- R5: With enable=1 and disable=1, nothing in the region is protected.
- R6: With enable=1 and disable=0, only addresses inside the window are protected.
- R7: With enable=0 and disable=1, the whole region is protected.
- R8: With enable=0 and disable=0, addresses inside the window are unprotected and the rest of the region is protected.
- R9: `req_kind` encodes 00 = program, 01 = sector erase, 10 = block erase, 11 = reserved (treated as block erase). Program and sector erase are rejected when their address is protected. A block erase is rejected when any address of the region is protected.
- R10: A request with `req_valid` high in one cycle gets `rsp_valid` in the next cycle. It then gets exactly one of `rsp_ok`, `rsp_reject` and `rsp_foreign`. The verdict uses the configuration as stored before any write in the same cycle.
- R11: A request whose address is below 0x3_C000 gets `rsp_foreign` and leaves `viol_flag` unchanged.
- R12: `viol_flag` rises together with `rsp_reject` and stays high until a cycle with `viol_clr` high and no new reject. If a clear and a reject arrive together, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| nv_cfg | input | 8 | Nonvolatile configuration byte loaded during reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Stored configuration byte |
| viol_clr | input | 1 | Write-1 clear of the violation flag |
| req_valid | input | 1 | Command request valid |
| req_kind | input | 2 | Command kind (see R9) |
| req_addr | input | ADDR_W | Global target address |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_ok | output | 1 | Request allowed and forwarded to the array |
| rsp_reject | output | 1 | Request refused for protection |
| rsp_foreign | output | 1 | Address outside the guarded region |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
A wrong stored configuration shows up at `cfg_rd_data` in the cycle after the write that corrupts it. A wrong window decode or mode decode turns an `rsp_ok` into an `rsp_reject`, or the reverse, in the cycle right after the request. So the bench probes both sides of each window boundary for every mode. A stuck or lost violation flag shows on `viol_flag` in the same cycle as the verdict that should have moved it. A clear that collides with a reject is judged on the following cycle.

// File: rtl/pflash_guard_pkg.sv
package pflash_guard_pkg;

   localparam int CFG_W   = 8;
   localparam int EN_POS  = 7;
   localparam int DIS_POS = 5;
   localparam int SZ_HI   = 4;
   localparam int SZ_LO   = 3;
   localparam int SIZE_W  = SZ_HI - SZ_LO + 1;
   localparam int NCODES  = 1 << SIZE_W;

   typedef enum logic [1:0] {
      CMD_PROG  = 2'b00,
      CMD_SECT  = 2'b01,
      CMD_BLOCK = 2'b10,
      CMD_RSVD  = 2'b11
   } cmd_kind_e;

   typedef enum logic [1:0] {
      MODE_LOW_ONLY  = 2'b00,
      MODE_ALL       = 2'b01,
      MODE_HIGH_ONLY = 2'b10,
      MODE_OPEN      = 2'b11
   } prot_mode_e;

   typedef struct packed {
      logic ok;
      logic reject;
      logic foreign;
   } verdict_t;

   function automatic prot_mode_e mode_of(input logic en, input logic dis);
      return prot_mode_e'({en, dis});
   endfunction

endpackage

// File: rtl/pg_cfg_reg.sv
module pg_cfg_reg
   import pflash_guard_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] nv_cfg,
   input  logic             wr_en,
   input  logic             wr_en_bit,
   input  logic             wr_dis_bit,
   input  logic [SIZE_W-1:0] wr_size,
   output logic [CFG_W-1:0] cfg_q
);

   logic [CFG_W-1:0] cfg_nxt;

   always_comb begin
      cfg_nxt          = cfg_q;
      cfg_nxt[EN_POS]  = wr_en_bit;
      cfg_nxt[DIS_POS] = wr_dis_bit;
      if (cfg_q[DIS_POS]) begin
         cfg_nxt[SZ_HI:SZ_LO] = wr_size;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= nv_cfg;
      end else if (wr_en) begin
         cfg_q <= cfg_nxt;
      end
   end

endmodule

// File: rtl/pg_window_decode.sv
module pg_window_decode
   import pflash_guard_pkg::*;
#(
   parameter int                ADDR_W       = 18,
   parameter int                REGION_LOG2  = 14,
   parameter int                MIN_WIN_LOG2 = 11,
   parameter logic [ADDR_W-1:0] REGION_BASE  = 18'h3C000
)(
   input  logic [ADDR_W-1:MIN_WIN_LOG2] addr_hi,
   input  logic [SIZE_W-1:0]            size_code,
   output logic                         in_region,
   output logic                         in_window,
   output logic                         window_full
);

   localparam int TAG_W = ADDR_W - REGION_LOG2;
   localparam logic [TAG_W-1:0] REGION_TAG = REGION_BASE[ADDR_W-1:REGION_LOG2];

   logic [NCODES-1:0] code_hit;
   logic [NCODES-1:0] code_full;
   logic [REGION_LOG2-1:MIN_WIN_LOG2] offs;

   assign offs      = addr_hi[REGION_LOG2-1:MIN_WIN_LOG2];
   assign in_region = (addr_hi[ADDR_W-1:REGION_LOG2] == REGION_TAG);

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam int WL = MIN_WIN_LOG2 + c;
      if (WL >= REGION_LOG2) begin : g_whole
         assign code_hit[c]  = 1'b1;
         assign code_full[c] = 1'b1;
      end else begin : g_part
         assign code_hit[c]  = &offs[REGION_LOG2-1:WL];
         assign code_full[c] = 1'b0;
      end
   end

   assign in_window   = code_hit[size_code];
   assign window_full = code_full[size_code];

endmodule

// File: rtl/pg_access_judge.sv
module pg_access_judge
   import pflash_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   input  logic       in_region,
   input  logic       in_window,
   input  logic       window_full,
   input  logic       cfg_en,
   input  logic       cfg_dis,
   input  logic       viol_clr,
   output logic       rsp_valid,
   output verdict_t   rsp,
   output logic       viol_flag
);

   prot_mode_e mode;
   logic       addr_prot;
   logic       any_prot;
   logic       refuse;
   verdict_t   verdict_d;

   assign mode = mode_of(cfg_en, cfg_dis);

   always_comb begin
      unique case (mode)
         MODE_OPEN:      begin addr_prot = 1'b0;       any_prot = 1'b0;         end
         MODE_HIGH_ONLY: begin addr_prot = in_window;  any_prot = 1'b1;         end
         MODE_ALL:       begin addr_prot = 1'b1;       any_prot = 1'b1;         end
         default:        begin addr_prot = !in_window; any_prot = !window_full; end
      endcase
   end

   always_comb begin
      unique case (cmd_kind_e'(req_kind))
         CMD_BLOCK, CMD_RSVD: refuse = any_prot;
         default:             refuse = addr_prot;
      endcase
   end

   always_comb begin
      verdict_d.foreign = !in_region;
      verdict_d.reject  = in_region && refuse;
      verdict_d.ok      = in_region && !refuse;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp       <= '0;
         viol_flag <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp       <= req_valid ? verdict_d : '0;
         if (req_valid && verdict_d.reject) begin
            viol_flag <= 1'b1;
         end else if (viol_clr) begin
            viol_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pflash_guard.sv
module pflash_guard
   import pflash_guard_pkg::*;
#(
   parameter int                ADDR_W       = 18,
   parameter int                REGION_LOG2  = 14,
   parameter int                MIN_WIN_LOG2 = 11,
   parameter logic [ADDR_W-1:0] REGION_BASE  = 18'h3C000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        nv_cfg,
   input  logic              cfg_wr_en,
   input  logic [7:0]        cfg_wr_data,
   output logic [7:0]        cfg_rd_data,
   input  logic              viol_clr,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              rsp_reject,
   output logic              rsp_foreign,
   output logic              viol_flag
);

   localparam logic [REGION_LOG2-1:0] LOW_MASK = '1;

   if (ADDR_W <= REGION_LOG2) begin : g_bad_width
      $error("pflash_guard: ADDR_W must exceed REGION_LOG2");
   end
   if (MIN_WIN_LOG2 + NCODES - 1 > REGION_LOG2) begin : g_bad_window
      $error("pflash_guard: largest window exceeds the region");
   end
   if ((REGION_BASE[REGION_LOG2-1:0] & LOW_MASK) != '0) begin : g_bad_base
      $error("pflash_guard: REGION_BASE must be aligned to the region size");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             in_region;
   logic             in_window;
   logic             window_full;
   verdict_t         rsp;

   pg_cfg_reg i_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .nv_cfg     (nv_cfg),
      .wr_en      (cfg_wr_en),
      .wr_en_bit  (cfg_wr_data[EN_POS]),
      .wr_dis_bit (cfg_wr_data[DIS_POS]),
      .wr_size    (cfg_wr_data[SZ_HI:SZ_LO]),
      .cfg_q      (cfg_q)
   );

   pg_window_decode #(
      .ADDR_W       (ADDR_W),
      .REGION_LOG2  (REGION_LOG2),
      .MIN_WIN_LOG2 (MIN_WIN_LOG2),
      .REGION_BASE  (REGION_BASE)
   ) i_dec (
      .addr_hi     (req_addr[ADDR_W-1:MIN_WIN_LOG2]),
      .size_code   (cfg_q[SZ_HI:SZ_LO]),
      .in_region   (in_region),
      .in_window   (in_window),
      .window_full (window_full)
   );

   pg_access_judge i_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_kind    (req_kind),
      .in_region   (in_region),
      .in_window   (in_window),
      .window_full (window_full),
      .cfg_en      (cfg_q[EN_POS]),
      .cfg_dis     (cfg_q[DIS_POS]),
      .viol_clr    (viol_clr),
      .rsp_valid   (rsp_valid),
      .rsp         (rsp),
      .viol_flag   (viol_flag)
   );

   assign cfg_rd_data = cfg_q;
   assign rsp_ok      = rsp.ok;
   assign rsp_reject  = rsp.reject;
   assign rsp_foreign = rsp.foreign;

endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
   parameter int                ADDR_W      = 18,
   parameter logic [ADDR_W-1:0] REGION_BASE = 18'h3C000
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [7:0]        cfg_wr_data,
   input logic [7:0]        cfg_rd_data,
   input logic              viol_clr,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic              rsp_reject,
   input logic              rsp_foreign,
   input logic              viol_flag
);

   // R10
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R10
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_ok && !rsp_reject && !rsp_foreign);

   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_ok, rsp_reject, rsp_foreign}) == 1);

   // R12
   flag_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_reject |-> viol_flag);

   // R12
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag && !viol_clr |=> viol_flag);

   // R12
   flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_flag) |-> rsp_reject);

   // R3
   size_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_data[5] |=> cfg_rd_data[4:3] == $past(cfg_rd_data[4:3]));

   // R2
   reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en && (cfg_wr_data[6] != cfg_rd_data[6] || cfg_wr_data[2:0] != cfg_rd_data[2:0])
      |=> $stable({cfg_rd_data[6], cfg_rd_data[2:0]}));

   // R7
   all_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !cfg_rd_data[7] && cfg_rd_data[5] && req_addr >= REGION_BASE
      |=> rsp_reject);

   // R5
   open_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && cfg_rd_data[7] && cfg_rd_data[5] && req_addr >= REGION_BASE
      |=> rsp_ok);

   // R11
   foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr < REGION_BASE |=> rsp_foreign);

endmodule

bind pflash_guard pg_guard_chk #(
   .ADDR_W      (ADDR_W),
   .REGION_BASE (REGION_BASE)
) i_guard_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_wr_data (cfg_wr_data),
   .cfg_rd_data (cfg_rd_data),
   .viol_clr    (viol_clr),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .rsp_valid   (rsp_valid),
   .rsp_ok      (rsp_ok),
   .rsp_reject  (rsp_reject),
   .rsp_foreign (rsp_foreign),
   .viol_flag   (viol_flag)
);

// File: tb/test_pflash_guard.sv
module test_pflash_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  nv_cfg = 8'hFF;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_data = '0;
   logic [7:0]  cfg_rd_data;
   logic        viol_clr = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [17:0] req_addr = '0;
   logic        rsp_valid, rsp_ok, rsp_reject, rsp_foreign, viol_flag;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;
   logic [7:0] shadow;
   bit   exp_flag;

   always #4 clk = ~clk;

   pflash_guard i_pflash_guard (
      .clk(clk), .rst_n(rst_n), .nv_cfg(nv_cfg),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .viol_clr(viol_clr), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_reject(rsp_reject),
      .rsp_foreign(rsp_foreign), .viol_flag(viol_flag)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // 0 = ok, 1 = reject, 2 = foreign
   function automatic int model(input logic [7:0] c, input logic [1:0] k, input logic [17:0] a);
      int base;
      bit inw, full, prot, anyp, bad;
      if (a < 18'h3C000) return 2;
      base = 32'h40000 - (32'h800 << c[4:3]);
      inw  = (int'(a) >= base);
      full = (c[4:3] == 2'b11);
      case ({c[7], c[5]})
         2'b11:   begin prot = 1'b0; anyp = 1'b0;  end
         2'b10:   begin prot = inw;  anyp = 1'b1;  end
         2'b01:   begin prot = 1'b1; anyp = 1'b1;  end
         default: begin prot = !inw; anyp = !full; end
      endcase
      bad = k[1] ? anyp : prot;
      return bad ? 1 : 0;
   endfunction

   task automatic do_reset(input logic [7:0] nv);
      @(negedge clk);
      rst_n  = 1'b0;
      nv_cfg = nv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      shadow = nv;
      exp_flag = 1'b0;
   endtask

   task automatic wr_cfg(input string req, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      shadow = {d[7], shadow[6], d[5], shadow[5] ? d[4:3] : shadow[4:3], shadow[2:0]};
      chk(req, "cfg after write", {24'h0, cfg_rd_data}, {24'h0, shadow});
   endtask

   task automatic set_mode(input bit en, input bit dis, input logic [1:0] sz);
      wr_cfg("R3", {en, 1'b0, 1'b1, sz, 3'b000});
      wr_cfg("R3", {en, 1'b0, 1'b1, sz, 3'b000});
      wr_cfg("R2", {en, 1'b0, dis, sz, 3'b000});
   endtask

   task automatic probe(input string req, input logic [1:0] k, input logic [17:0] a);
      int v;
      v = model(shadow, k, a);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = k;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (v == 1) exp_flag = 1'b1;
      chk(req, $sformatf("verdict k=%0d a=%h", k, a),
          {28'h0, rsp_valid, rsp_ok, rsp_reject, rsp_foreign},
          {28'h0, 1'b1, v == 0, v == 1, v == 2});
      chk("R12", "flag", {31'h0, viol_flag}, {31'h0, exp_flag});
   endtask

   task automatic clear_flag();
      @(negedge clk);
      viol_clr = 1'b1;
      @(negedge clk);
      viol_clr = 1'b0;
      exp_flag = 1'b0;
      chk("R12", "flag after clear", {31'h0, viol_flag}, 32'h0);
   endtask

   task automatic t_reset();
      do_reset(8'hFF);
      chk("R1", "cfg loaded FF", {24'h0, cfg_rd_data}, 32'hFF);
      chk("R1", "idle outputs", {27'h0, rsp_valid, rsp_ok, rsp_reject, rsp_foreign, viol_flag}, 32'h0);
      do_reset(8'h20);
      chk("R1", "cfg loaded 20", {24'h0, cfg_rd_data}, 32'h20);
      probe("R1", 2'b10, 18'h3C000);
   endtask

   task automatic t_writes();
      do_reset(8'hFF);
      wr_cfg("R2", 8'h00);   // size written while disable stored 1 -> 0x47
      chk("R2", "reserved kept", {24'h0, cfg_rd_data}, 32'h47);
      wr_cfg("R3", 8'hB8);   // disable stored 0: size stays 00 -> 0xE7
      chk("R3", "size locked", {24'h0, cfg_rd_data}, 32'hE7);
      wr_cfg("R3", 8'h98);   // disable stored 1: size 11 taken -> 0xDF
      chk("R3", "size taken", {24'h0, cfg_rd_data}, 32'hDF);
   endtask

   task automatic t_high_only();
      do_reset(8'hFF);
      set_mode(1'b1, 1'b0, 2'b01);
      probe("R6", 2'b00, 18'h3EFFF);
      probe("R4", 2'b00, 18'h3F000);
      probe("R6", 2'b01, 18'h3FFFF);
      probe("R9", 2'b10, 18'h3C000);
      set_mode(1'b1, 1'b0, 2'b00);
      probe("R4", 2'b00, 18'h3F7FF);
      probe("R4", 2'b01, 18'h3F800);
   endtask

   task automatic t_low_only();
      clear_flag();
      set_mode(1'b0, 1'b0, 2'b10);
      probe("R8", 2'b00, 18'h3DFFF);
      probe("R4", 2'b00, 18'h3E000);
      probe("R9", 2'b10, 18'h3FFFF);
      clear_flag();
      set_mode(1'b0, 1'b0, 2'b11);
      probe("R8", 2'b01, 18'h3C000);
      probe("R9", 2'b11, 18'h3D000);
      chk("R9", "flag untouched", {31'h0, viol_flag}, 32'h0);
   endtask

   task automatic t_all_and_open();
      set_mode(1'b0, 1'b1, 2'b00);
      probe("R7", 2'b00, 18'h3C000);
      probe("R7", 2'b01, 18'h3C7FF);
      probe("R9", 2'b10, 18'h3E000);
      clear_flag();
      set_mode(1'b1, 1'b1, 2'b00);
      probe("R5", 2'b00, 18'h3FFFF);
      probe("R5", 2'b10, 18'h3C000);
      probe("R9", 2'b11, 18'h3C000);
   endtask

   task automatic t_foreign();
      set_mode(1'b0, 1'b1, 2'b00);
      probe("R11", 2'b00, 18'h3BFFF);
      probe("R11", 2'b10, 18'h00000);
      chk("R11", "flag unchanged", {31'h0, viol_flag}, 32'h0);
   endtask

   task automatic t_timing_and_flag();
      set_mode(1'b1, 1'b1, 2'b00);
      // request and write in the same cycle: verdict uses old (open) config
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b00; req_addr = 18'h3C000;
      cfg_wr_en = 1'b1; cfg_wr_data = 8'h20;
      @(negedge clk);
      req_valid = 1'b0; cfg_wr_en = 1'b0;
      shadow = {1'b0, shadow[6], 1'b1, 2'b00, shadow[2:0]};
      chk("R10", "old config verdict", {30'h0, rsp_valid, rsp_ok}, 32'h3);
      @(negedge clk);
      chk("R10", "no response when idle", {31'h0, rsp_valid}, 32'h0);
      probe("R10", 2'b00, 18'h3C000);
      probe("R12", 2'b00, 18'h3FFFF);
      // clear and reject together: flag stays set
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b01; req_addr = 18'h3D000; viol_clr = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; viol_clr = 1'b0;
      chk("R12", "set wins over clear", {30'h0, rsp_reject, viol_flag}, 32'h3);
      clear_flag();
   endtask

   initial begin
      t_reset();
      t_writes();
      t_high_only();
      t_low_only();
      t_all_and_open();
      t_foreign();
      t_timing_and_flag();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule